// File: doc/BRIEF.md
# Fetch-stage branch target buffer

This block sits beside instruction memory in the fetch stage. Each cycle the fetch PC is split into an index and a tag and looked up in a direct-mapped table. Each valid entry records a branch address tag, the address the branch jumped to, and a small prediction counter. If the entry hits and its counter leans towards taken, the block proposes the stored target as the next PC. Otherwise it proposes the sequential address, which is the PC plus the instruction size.

Later in the pipeline, each branch resolves and reports its address, its outcome, its real target and a flag that says whether fetch guessed wrong. From that report the block allocates an entry for a taken branch that missed, or retrains or drops an entry that hit. When the guess was wrong, it raises a one-cycle redirect that kills the wrongly fetched instructions and carries the corrected PC. Two parameter-chosen policies govern entries that hit. The default keeps the entry and steps its saturating counter. The other policy drops the entry on any misprediction and uses a one-bit state.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset no entry is valid: every lookup misses (`pred_hit`=0), `redirect` is 0 and `redirect_pc` is 0.
- R2: On a miss, or on a hit whose counter top bit is 0, `pred_taken` is 0 and `next_pc` is `fetch_pc` + 4 in the same cycle.
- R3: A resolved taken branch that misses allocates an entry with its counter at all ones. From the next cycle, a lookup of that PC gives `pred_hit`=1, `pred_taken`=1 and `next_pc` equal to the reported target.
- R4: A resolved not-taken branch that misses allocates nothing, so its PC still misses afterwards.
- R5: The index is PC bits [IDX_W+1:2] and the tag is the PC bits above them. A PC sharing an index but differing in tag misses. Allocating it replaces the older entry, which then misses.
- R6: A resolve with `res_mispred`=1 makes `redirect` 1 in the following cycle only. `redirect_pc` is then the reported target if the branch was taken, or the branch PC + 4 if it was not taken. A resolve with `res_mispred`=0 raises no redirect.
- R7: In retrain mode (RETRAIN=1), a hit moves the counter one step towards the outcome and saturates at both ends. With PRED_W=2, a strongly taken entry needs two not-taken outcomes before it predicts not taken, and stays valid throughout.
- R8: In retrain mode, a taken resolve that hits replaces the stored target with the reported one.
- R9: In drop mode (RETRAIN=0), a mispredicted resolve that hits invalidates the entry, so its PC misses from the next cycle.
- R10: When a resolve writes the index being looked up in the same cycle, the lookup sees the written entry in that cycle.
- R11: While `res_valid` is 0, the resolve inputs change no entry and raise no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| pred_hit | output | 1 | Lookup found a valid entry with a matching tag |
| pred_taken | output | 1 | Hit and counter predicts taken |
| next_pc | output | PC_W | Proposed next fetch PC |
| res_valid | input | 1 | A branch resolve report is present |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Resolved branch was taken |
| res_target | input | PC_W | Actual target of the resolved branch |
| res_mispred | input | 1 | Fetch followed the wrong path for this branch |
| redirect | output | 1 | One-cycle kill and redirect request |
| redirect_pc | output | PC_W | Corrected fetch PC while `redirect` is 1 |

## Verification
The bench builds two copies side by side with a 4-bit index, so a 16-entry table makes index aliasing reachable with small addresses. The copy named `dut` uses a 2-bit counter in retrain mode, which exposes the hysteresis, the saturation and target replacement. The second copy uses a 1-bit state in drop mode, so the same resolve stream shows entries disappearing on a misprediction. Both copies keep same-cycle write forwarding enabled so the index-collision priority can be observed at the lookup outputs.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // Action applied to one table entry by a resolve report
   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_WRITE = 2'd1,
      UPD_CLEAR = 2'd2
   } btb_upd_e;

endpackage

// File: rtl/btb_counter.sv
module btb_counter #(
   parameter int PRED_W = 2
) (
   input  logic [PRED_W-1:0] cur,
   input  logic              taken,
   output logic [PRED_W-1:0] nxt
);
   localparam logic [PRED_W-1:0] CTR_MAX = {PRED_W{1'b1}};
   localparam logic [PRED_W-1:0] CTR_MIN = '0;

   generate
      if (PRED_W == 1) begin : g_flip
         // single state bit: invert only when the outcome disagrees
         always_comb begin
            if (cur == taken) nxt = cur;
            else              nxt = ~cur;
         end
      end else begin : g_sat
         always_comb begin
            if (taken) nxt = (cur == CTR_MAX) ? cur : cur + 1'b1;
            else       nxt = (cur == CTR_MIN) ? cur : cur - 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/btb_policy.sv
module btb_policy
   import btb_pkg::*;
#(
   parameter int PRED_W = 2
) (
   input  logic              res_valid,
   input  logic              res_hit,
   input  logic              res_taken,
   input  logic              drop_req,
   input  logic [PRED_W-1:0] cur_ctr,
   output btb_upd_e          act,
   output logic [PRED_W-1:0] new_ctr
);
   localparam logic [PRED_W-1:0] CTR_ALLOC = {PRED_W{1'b1}};

   logic [PRED_W-1:0] step_ctr;

   btb_counter #(.PRED_W(PRED_W)) u_ctr (
      .cur   (cur_ctr),
      .taken (res_taken),
      .nxt   (step_ctr)
   );

   always_comb begin
      act     = UPD_NONE;
      new_ctr = step_ctr;
      if (res_valid) begin
         if (!res_hit) begin
            if (res_taken) begin
               act     = UPD_WRITE;
               new_ctr = CTR_ALLOC;
            end
         end else if (drop_req) begin
            act = UPD_CLEAR;
         end else begin
            act = UPD_WRITE;
         end
      end
   end

endmodule

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int IDX_W  = 10,
   parameter int TAG_W  = 20,
   parameter int PRED_W = 2,
   parameter bit BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   // fetch-side lookup
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [PC_W-1:0]   lk_target,
   output logic [PRED_W-1:0] lk_ctr,
   // resolve-side lookup
   input  logic [IDX_W-1:0]  rs_idx,
   input  logic [TAG_W-1:0]  rs_tag,
   output logic              rs_hit,
   output logic [PC_W-1:0]   rs_target,
   output logic [PRED_W-1:0] rs_ctr,
   // write port
   input  btb_upd_e          wr_act,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PC_W-1:0]   wr_target,
   input  logic [PRED_W-1:0] wr_ctr
);
   localparam int DEPTH = 1 << IDX_W;

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic [PC_W-1:0]   tgt;
      logic [PRED_W-1:0] ctr;
   } entry_t;

   logic [DEPTH-1:0] valid_q;
   entry_t           mem_q [DEPTH];
   entry_t           wr_ent;
   entry_t           lk_ent;
   logic             lk_vld;
   entry_t           rs_ent;

   assign wr_ent = '{tag: wr_tag, tgt: wr_target, ctr: wr_ctr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         case (wr_act)
            UPD_WRITE: valid_q[wr_idx] <= 1'b1;
            UPD_CLEAR: valid_q[wr_idx] <= 1'b0;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_act == UPD_WRITE) mem_q[wr_idx] <= wr_ent;
   end

   generate
      if (BYPASS) begin : g_fwd
         // a same-cycle write to the looked-up index wins over stored state
         always_comb begin
            if (wr_act != UPD_NONE && wr_idx == lk_idx) begin
               lk_vld = (wr_act == UPD_WRITE);
               lk_ent = wr_ent;
            end else begin
               lk_vld = valid_q[lk_idx];
               lk_ent = mem_q[lk_idx];
            end
         end
      end else begin : g_nofwd
         always_comb begin
            lk_vld = valid_q[lk_idx];
            lk_ent = mem_q[lk_idx];
         end
      end
   endgenerate

   assign lk_hit    = lk_vld && (lk_ent.tag == lk_tag);
   assign lk_target = lk_ent.tgt;
   assign lk_ctr    = lk_ent.ctr;

   assign rs_ent    = mem_q[rs_idx];
   assign rs_hit    = valid_q[rs_idx] && (rs_ent.tag == rs_tag);
   assign rs_target = rs_ent.tgt;
   assign rs_ctr    = rs_ent.ctr;

   a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid_q == '0));

   a_r3_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act == UPD_WRITE) |=> valid_q[$past(wr_idx)]);

   a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act == UPD_CLEAR) |=> !valid_q[$past(wr_idx)]);

   a_r10_fwd_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS && wr_act == UPD_WRITE && wr_idx == lk_idx && wr_tag == lk_tag) |-> lk_hit);

endmodule

// File: rtl/btb_redirect.sv
module btb_redirect #(
   parameter int PC_W  = 32,
   parameter int OFS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            res_valid,
   input  logic            res_mispred,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_pc,
   input  logic [PC_W-1:0] res_target,
   output logic            redirect,
   output logic [PC_W-1:0] redirect_pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1 << OFS_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect    <= 1'b0;
         redirect_pc <= '0;
      end else begin
         redirect <= res_valid && res_mispred;
         if (res_valid && res_mispred)
            redirect_pc <= res_taken ? res_target : res_pc + STEP;
      end
   end

   a_r6_redirect_cause: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> $past(res_valid && res_mispred));

   a_r6_redirect_pc: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (redirect_pc == ($past(res_taken) ? $past(res_target) : $past(res_pc) + STEP)));

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
   import btb_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int IDX_W   = 10,
   parameter int OFS_W   = 2,
   parameter int PRED_W  = 2,
   parameter bit RETRAIN = 1'b1,
   parameter bit BYPASS  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] next_pc,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic            res_mispred,
   output logic            redirect,
   output logic [PC_W-1:0] redirect_pc
);
   localparam int              TAG_W = PC_W - IDX_W - OFS_W;
   localparam logic [PC_W-1:0] STEP  = PC_W'(1 << OFS_W);

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must lie in 1..12");
      end
      if (OFS_W < 0 || OFS_W > 4) begin : g_bad_ofs
         $error("OFS_W must lie in 0..4");
      end
      if (PRED_W < 1 || PRED_W > 4) begin : g_bad_pred
         $error("PRED_W must lie in 1..4");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("PC_W leaves no tag bits");
      end
   endgenerate

   logic [IDX_W-1:0]  lk_idx, rs_idx;
   logic [TAG_W-1:0]  lk_tag, rs_tag;
   logic              lk_hit, rs_hit;
   logic [PC_W-1:0]   lk_target, rs_target;
   logic [PRED_W-1:0] lk_ctr, rs_ctr;
   btb_upd_e          wr_act;
   logic [PRED_W-1:0] wr_ctr;
   logic [PC_W-1:0]   wr_target;
   logic              drop_req;

   assign lk_idx = fetch_pc[OFS_W +: IDX_W];
   assign lk_tag = fetch_pc[PC_W-1 -: TAG_W];
   assign rs_idx = res_pc[OFS_W +: IDX_W];
   assign rs_tag = res_pc[PC_W-1 -: TAG_W];

   assign drop_req  = res_mispred && (RETRAIN == 1'b0);
   assign wr_target = res_taken ? res_target : rs_target;

   btb_store #(
      .PC_W   (PC_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .PRED_W (PRED_W),
      .BYPASS (BYPASS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (lk_idx),
      .lk_tag    (lk_tag),
      .lk_hit    (lk_hit),
      .lk_target (lk_target),
      .lk_ctr    (lk_ctr),
      .rs_idx    (rs_idx),
      .rs_tag    (rs_tag),
      .rs_hit    (rs_hit),
      .rs_target (rs_target),
      .rs_ctr    (rs_ctr),
      .wr_act    (wr_act),
      .wr_idx    (rs_idx),
      .wr_tag    (rs_tag),
      .wr_target (wr_target),
      .wr_ctr    (wr_ctr)
   );

   btb_policy #(.PRED_W(PRED_W)) u_policy (
      .res_valid (res_valid),
      .res_hit   (rs_hit),
      .res_taken (res_taken),
      .drop_req  (drop_req),
      .cur_ctr   (rs_ctr),
      .act       (wr_act),
      .new_ctr   (wr_ctr)
   );

   btb_redirect #(.PC_W(PC_W), .OFS_W(OFS_W)) u_redirect (
      .clk         (clk),
      .rst_n       (rst_n),
      .res_valid   (res_valid),
      .res_mispred (res_mispred),
      .res_taken   (res_taken),
      .res_pc      (res_pc),
      .res_target  (res_target),
      .redirect    (redirect),
      .redirect_pc (redirect_pc)
   );

   assign pred_hit   = lk_hit;
   assign pred_taken = lk_hit && lk_ctr[PRED_W-1];
   assign next_pc    = pred_taken ? lk_target : fetch_pc + STEP;

   a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (!pred_taken && next_pc == fetch_pc + STEP));

   a_r4_no_alloc_untaken: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !rs_hit && !res_taken) |-> (wr_act == UPD_NONE));

   a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (wr_act == UPD_NONE));

   a_r9_drop_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (!RETRAIN && res_valid && res_mispred && rs_hit) |-> (wr_act == UPD_CLEAR));

endmodule

// File: tb/tb_fetch_target_buffer.sv
`timescale 1ns/1ps
module tb_fetch_target_buffer;
   localparam int PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic            res_valid = 1'b0;
   logic [PC_W-1:0] res_pc = '0;
   logic            res_taken = 1'b0;
   logic [PC_W-1:0] res_target = '0;
   logic            res_mispred = 1'b0;

   logic            a_hit, a_tk, a_rd, b_hit, b_tk, b_rd;
   logic [PC_W-1:0] a_np, a_rpc, b_np, b_rpc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fetch_target_buffer #(.PC_W(PC_W), .IDX_W(4), .OFS_W(2), .PRED_W(2),
                         .RETRAIN(1'b1), .BYPASS(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(a_hit), .pred_taken(a_tk), .next_pc(a_np),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_mispred(res_mispred),
      .redirect(a_rd), .redirect_pc(a_rpc));

   fetch_target_buffer #(.PC_W(PC_W), .IDX_W(4), .OFS_W(2), .PRED_W(1),
                         .RETRAIN(1'b0), .BYPASS(1'b1)) dut_drop (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(b_hit), .pred_taken(b_tk), .next_pc(b_np),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_mispred(res_mispred),
      .redirect(b_rd), .redirect_pc(b_rpc));

   task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // lookup on both copies, compare hit/taken/next
   task automatic look(input string req, input logic [PC_W-1:0] pc,
                       input logic eh_a, input logic et_a, input logic [PC_W-1:0] en_a,
                       input logic eh_b, input logic et_b, input logic [PC_W-1:0] en_b);
      fetch_pc = pc;
      #1;
      chk({req, " retrain hit"},   PC_W'(a_hit), PC_W'(eh_a));
      chk({req, " retrain taken"}, PC_W'(a_tk),  PC_W'(et_a));
      chk({req, " retrain next"},  a_np, en_a);
      chk({req, " drop hit"},      PC_W'(b_hit), PC_W'(eh_b));
      chk({req, " drop taken"},    PC_W'(b_tk),  PC_W'(et_b));
      chk({req, " drop next"},     b_np, en_b);
   endtask

   // one resolve cycle, then redirect checks on the following cycles
   task automatic resolve(input string req, input logic [PC_W-1:0] pc, input logic tk,
                          input logic [PC_W-1:0] tg, input logic mp, input logic [PC_W-1:0] exp_rpc);
      @(negedge clk);
      res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tg; res_mispred = mp;
      @(negedge clk);
      res_valid = 1'b0; res_mispred = 1'b0;
      #1;
      chk({req, " redirect"}, PC_W'(a_rd), PC_W'(mp));
      chk({req, " redirect copy"}, PC_W'(b_rd), PC_W'(mp));
      if (mp) begin
         chk({req, " redirect_pc"}, a_rpc, exp_rpc);
         chk({req, " redirect_pc copy"}, b_rpc, exp_rpc);
      end
      @(negedge clk);
      #1;
      chk({req, " redirect one cycle"}, PC_W'(a_rd), '0);
   endtask

   task automatic t_reset();
      chk("R1 redirect after reset", PC_W'(a_rd), '0);
      chk("R1 redirect_pc after reset", a_rpc, '0);
      look("R1 empty", 32'h100, 0, 0, 32'h104, 0, 0, 32'h104);
      look("R1 R2 empty", 32'h3FC, 0, 0, 32'h400, 0, 0, 32'h400);
   endtask

   task automatic t_allocate();
      resolve("R3 R6 alloc", 32'h100, 1, 32'h400, 1, 32'h400);
      look("R3 hit", 32'h100, 1, 1, 32'h400, 1, 1, 32'h400);
      look("R2 neighbour miss", 32'h104, 0, 0, 32'h108, 0, 0, 32'h108);
   endtask

   task automatic t_untaken_miss();
      resolve("R4 R6 no redirect", 32'h208, 0, 32'h900, 0, 32'h0);
      look("R4 no alloc", 32'h208, 0, 0, 32'h20C, 0, 0, 32'h20C);
   endtask

   task automatic t_hysteresis();
      resolve("R6 R7 first not-taken", 32'h100, 0, 32'h0, 1, 32'h104);
      look("R7 still taken / R9 dropped", 32'h100, 1, 1, 32'h400, 0, 0, 32'h104);
      resolve("R7 second not-taken", 32'h100, 0, 32'h0, 1, 32'h104);
      look("R7 R2 hit predicts not taken", 32'h100, 1, 0, 32'h104, 0, 0, 32'h104);
      resolve("R7 taken again", 32'h100, 1, 32'h400, 1, 32'h400);
      look("R7 one step back to taken", 32'h100, 1, 1, 32'h400, 1, 1, 32'h400);
   endtask

   task automatic t_new_target();
      resolve("R8 R9 target change", 32'h100, 1, 32'h500, 1, 32'h500);
      look("R8 new target / R9 dropped", 32'h100, 1, 1, 32'h500, 0, 0, 32'h104);
   endtask

   task automatic t_alias();
      look("R5 alias misses", 32'h140, 0, 0, 32'h144, 0, 0, 32'h144);
      resolve("R5 alias alloc", 32'h140, 1, 32'h600, 1, 32'h600);
      look("R5 alias hit", 32'h140, 1, 1, 32'h600, 1, 1, 32'h600);
      look("R5 old entry replaced", 32'h100, 0, 0, 32'h104, 0, 0, 32'h104);
   endtask

   task automatic t_bypass();
      @(negedge clk);
      res_valid = 1'b1; res_pc = 32'h1C; res_taken = 1'b1; res_target = 32'h800; res_mispred = 1'b1;
      look("R10 same-cycle write seen", 32'h1C, 1, 1, 32'h800, 1, 1, 32'h800);
      @(negedge clk);
      res_valid = 1'b0; res_mispred = 1'b0;
      #1;
      chk("R6 R10 redirect", PC_W'(a_rd), 32'd1);
      chk("R6 R10 redirect_pc", a_rpc, 32'h800);
   endtask

   task automatic t_idle();
      @(negedge clk);
      res_valid = 1'b0; res_pc = 32'h24; res_taken = 1'b1; res_target = 32'hA00; res_mispred = 1'b1;
      @(negedge clk);
      #1;
      chk("R11 no redirect when idle", PC_W'(a_rd), '0);
      chk("R11 no redirect when idle copy", PC_W'(b_rd), '0);
      look("R11 no entry written", 32'h24, 0, 0, 32'h28, 0, 0, 32'h28);
      res_mispred = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8.0 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_allocate();
      t_untaken_miss();
      t_hysteresis();
      t_new_target();
      t_alias();
      t_bypass();
      t_idle();
      finish_run();
   end

endmodule